// File: doc/BRIEF.md
# Voted Clock Branch Gate Controller

This block is the register-side model of a group of clock branches and one PLL. It decides when each branch clock may run and when the PLL counts as locked. A branch can be switched on in two ways. Software sets the direct enable bit in that branch's control word, or a requester sets the branch's bit in a shared branch vote word. The PLL is switched on by setting bit 0 of a PLL vote word.

No request takes effect at once. Each branch and the PLL follow their request only after a fixed settling time. Software has to poll the status fields to see the change. The branch control word shows an off flag in bit 31 and a 4-bit state field in bits 31:28. The PLL status word shows an active flag at a parameterised bit position. A requester that finds the PLL already active does not need to wait.

The register port is a plain synchronous one. Writes take effect at the clock edge where `wr_en` is sampled. Read data is registered: it appears one cycle after `rd_en` and holds until the next read. The port has no data stream, so there is no valid/ready handshake. The block drives one gated clock-enable output per branch and one PLL-active output.

Register map (word addresses):
- Branch control words sit at addresses 0 to NUM_BRANCH-1.
- The branch vote word is at address 8.
- The PLL vote word is at address 9.
- The PLL status word is at address 10.
- Any other address reads 0.

Top module: `cbg_top`

## Requirements
- R1: After reset, every branch is off and every clock-enable output is low. Each branch control word reads 0x8000_0000. The branch vote word reads 0. The PLL vote word reads 0. The PLL status word reads 0, and `pll_active` is low.
- R2: Writing 1 to bit 0 of a branch control word requests that branch. Its `clk_en` bit rises exactly SETTLE_CYC clock edges after the write edge, and bit 31 of the control word clears at the same time. Before that, the word reads 0x8000_0001.
- R3: Setting bit VOTE_LSB+i of the branch vote word requests branch i. The state field in bits 31:28 encodes the branch as follows: 0x8 when off, 0x0 when on with the direct enable set, and 0x2 when on through the vote alone.
- R4: When both the direct enable and the vote bit of a running branch are cleared, the branch keeps running for SETTLE_CYC edges. Then `clk_en` falls and bit 31 reads 1 again.
- R5: If a request is withdrawn before its settling time has elapsed, the branch never turns on.
- R6: Writing 1 to bit 0 of the PLL vote word makes the active flag (bit PLL_ACT_BIT of the PLL status word) and `pll_active` go high LOCK_CYC edges after the write edge.
- R7: While the PLL is active and its vote is held, writing the vote again leaves `pll_active` high in every cycle.
- R8: Writes to read-only bits are ignored. This covers branch status bits 31:1, the whole PLL status word, and vote word bits outside VOTE_LSB..VOTE_LSB+NUM_BRANCH-1. Unmapped addresses read 0.
- R9: A `clk_en` bit is high only while that branch's status reports on (state field 0x0 or 0x2).
- R10: `rdata` changes only on the edge after an `rd_en` cycle and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| clk_en | output | NUM_BRANCH | Gated clock enable, one bit per branch |
| pll_active | output | 1 | PLL locked and running |

## Verification
A counter that is stuck or cleared at the wrong time moves the edge of `clk_en` or `pll_active` away from its exact settling cycle. The bench checks these outputs on every cycle around a request, so a shift of one cycle is caught. A wrong choice of state encoding shows up on the next read of the branch word, in bits 31:28. A vote or status bit that stores write data it should ignore shows up on the next read of that word. A request that should have been abandoned but latches anyway raises `clk_en` within twice the settling window.

// File: rtl/cbg_pkg.sv
package cbg_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_BVOTE = 4'h8;
  localparam logic [ADDR_W-1:0] A_PVOTE = 4'h9;
  localparam logic [ADDR_W-1:0] A_PSTAT = 4'hA;

  // status field reported in bits 31:28 of a branch control word
  typedef enum logic [3:0] {
    ST_ON_DIRECT = 4'h0,
    ST_ON_VOTED  = 4'h2,
    ST_OFF       = 4'h8
  } br_state_e;
endpackage

// File: rtl/cbg_settle.sv
// Delayed follower: 'run' takes the value of 'req' once req has differed
// from run for LAT consecutive edges; any return of req cancels the count.
module cbg_settle #(
  parameter int unsigned LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic run
);
  localparam int unsigned CW = $clog2(LAT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (req == run) begin
      cnt <= '0;
    end else if (cnt == CW'(LAT - 1)) begin
      run <= req;
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_HOLD_WHEN_MATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (req == run) |=> $stable(run)); // R5
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(LAT)); // R2
  AST_STAY_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!req && !run) |=> !run); // R4
endmodule

// File: rtl/cbg_branch.sv
// One clock branch: merges direct and voted requests, settles, encodes state.
module cbg_branch
  import cbg_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  logic      vote,
  output logic      run,
  output br_state_e state
);
  logic req;

  assign req = en | vote;

  cbg_settle #(.LAT(SETTLE_CYC)) u_settle (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (req),
    .run  (run)
  );

  always_comb begin
    if (!run)    state = ST_OFF;
    else if (en) state = ST_ON_DIRECT;
    else         state = ST_ON_VOTED;
  end

  AST_ON_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> $past(req)); // R3
endmodule

// File: rtl/cbg_top.sv
module cbg_top
  import cbg_pkg::*;
#(
  parameter int unsigned NUM_BRANCH  = 4,
  parameter int unsigned SETTLE_CYC  = 4,
  parameter int unsigned LOCK_CYC    = 6,
  parameter int unsigned VOTE_LSB    = 10,
  parameter int unsigned PLL_ACT_BIT = 17
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [3:0]            addr,
  input  logic [31:0]           wdata,
  output logic [31:0]           rdata,
  output logic [NUM_BRANCH-1:0] clk_en,
  output logic                  pll_active
);
  localparam logic [REG_W-1:0] VOTE_MASK =
    ((REG_W'(1) << NUM_BRANCH) - REG_W'(1)) << VOTE_LSB;

  logic [REG_W-1:0]      bvote;
  logic                  pvote;
  logic [NUM_BRANCH-1:0] br_en;
  br_state_e             br_st   [NUM_BRANCH];
  logic [REG_W-1:0]      br_word [NUM_BRANCH];
  logic [REG_W-1:0]      rd_word;

  // shared vote words
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bvote <= '0;
      pvote <= 1'b0;
    end else if (wr_en) begin
      if (addr == A_BVOTE) bvote <= wdata & VOTE_MASK;
      if (addr == A_PVOTE) pvote <= wdata[0];
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_BRANCH; g++) begin : g_br
      always_ff @(posedge clk) begin
        if (!rst_n)                              br_en[g] <= 1'b0;
        else if (wr_en && addr == ADDR_W'(g))    br_en[g] <= wdata[0];
      end

      cbg_branch #(.SETTLE_CYC(SETTLE_CYC)) u_branch (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (br_en[g]),
        .vote (bvote[VOTE_LSB + g]),
        .run  (clk_en[g]),
        .state(br_st[g])
      );

      assign br_word[g] = {br_st[g], 27'd0, br_en[g]};

      AST_CLKEN_ONLY_ON: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en[g] |-> (br_st[g] != ST_OFF)); // R9
    end
  endgenerate

  cbg_settle #(.LAT(LOCK_CYC)) u_pll (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (pvote),
    .run  (pll_active)
  );

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_BRANCH; i++)
      if (addr == ADDR_W'(i)) rd_word = br_word[i];
    if (addr == A_BVOTE)      rd_word = bvote;
    else if (addr == A_PVOTE) rd_word = REG_W'(pvote);
    else if (addr == A_PSTAT) rd_word = REG_W'(pll_active) << PLL_ACT_BIT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_word;
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R10
  AST_PLL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_active && pvote) |=> pll_active); // R7
  AST_VOTE_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (bvote & ~VOTE_MASK) == '0); // R8
endmodule

// File: tb/tb_cbg_top.sv
`timescale 1ns/1ps
module tb_cbg_top;
  localparam int NB = 4, SETTLE = 4, LOCK = 6, VLSB = 10, PBIT = 17;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NB-1:0] clk_en;
  logic pll_active;
  int total = 0, bad = 0;

  always #2 clk = ~clk; // 250 MHz

  cbg_top #(.NUM_BRANCH(NB), .SETTLE_CYC(SETTLE), .LOCK_CYC(LOCK),
            .VOTE_LSB(VLSB), .PLL_ACT_BIT(PBIT)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .clk_en(clk_en), .pll_active(pll_active));

  typedef struct packed {
    logic [1:0]  op;   // 0 write, 1 read-check, 2 idle d cycles
    logic [3:0]  a;
    logic [31:0] d;
    logic [3:0]  tag;
  } vec_t;
  localparam logic [1:0] OW = 2'd0, ORD = 2'd1, OI = 2'd2;
  localparam int NV = 31;
  localparam vec_t VEC [NV] = '{
    '{ORD, 4'h0, 32'h8000_0000, 4'd1},  // R1 branch off after reset
    '{ORD, 4'h8, 32'h0,         4'd1},  // R1
    '{ORD, 4'hA, 32'h0,         4'd1},  // R1
    '{OW,  4'h0, 32'h1,         4'd2},  // R2 direct enable
    '{ORD, 4'h0, 32'h8000_0001, 4'd2},  // R2 still settling
    '{OI,  4'h0, 32'd4,         4'd2},
    '{ORD, 4'h0, 32'h0000_0001, 4'd2},  // R2 on
    '{OW,  4'h8, 32'h0000_0800, 4'd3},  // R3 vote branch 1
    '{ORD, 4'h8, 32'h0000_0800, 4'd3},
    '{OI,  4'h0, 32'd4,         4'd3},
    '{ORD, 4'h1, 32'h2000_0000, 4'd3},  // R3 on by vote
    '{OW,  4'h1, 32'hFFFF_FFFF, 4'd8},  // R8 status bits read-only
    '{ORD, 4'h1, 32'h0000_0001, 4'd8},  // R8 / R3 direct+vote -> 0x0
    '{OW,  4'h1, 32'h0,         4'd3},
    '{ORD, 4'h1, 32'h2000_0000, 4'd3},  // R3 vote alone keeps it on
    '{OW,  4'h8, 32'h0,         4'd4},  // R4 drop vote
    '{ORD, 4'h1, 32'h2000_0000, 4'd4},  // R4 still running
    '{OI,  4'h0, 32'd4,         4'd4},
    '{ORD, 4'h1, 32'h8000_0000, 4'd4},  // R4 off again
    '{ORD, 4'hA, 32'h0,         4'd6},  // R6 inactive
    '{OW,  4'h9, 32'h1,         4'd6},  // R6 vote PLL
    '{ORD, 4'hA, 32'h0,         4'd6},
    '{OI,  4'h0, 32'd6,         4'd6},
    '{ORD, 4'hA, 32'h0002_0000, 4'd6},  // R6 active flag
    '{ORD, 4'h9, 32'h1,         4'd6},
    '{OW,  4'hA, 32'h0,         4'd8},  // R8 write status ignored
    '{ORD, 4'hA, 32'h0002_0000, 4'd8},
    '{OW,  4'h8, 32'hFFFF_FFFF, 4'd8},  // R8 only votable bits kept
    '{ORD, 4'h8, 32'h0000_3C00, 4'd8},
    '{OW,  4'h8, 32'h0,         4'd8},
    '{ORD, 4'hF, 32'h0,         4'd8}   // R8 unmapped reads 0
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(posedge clk); @(negedge clk); rd_en = 1'b0; v = rdata;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    logic [31:0] v, held;
    int lowcnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(clk_en == '0 && !pll_active, "R1", {27'd0, pll_active, clk_en}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        OW:  wr(VEC[i].a, VEC[i].d);
        ORD: begin
          rd(VEC[i].a, v);
          chk(v === VEC[i].d, $sformatf("R%0d", VEC[i].tag), v, VEC[i].d);
        end
        default: repeat (VEC[i].d) @(negedge clk);
      endcase
    end

    // R2: exact rise latency on branch 2
    wr(4'h2, 32'h1);
    lowcnt = 0;
    for (int k = 0; k < SETTLE; k++) begin
      if (!clk_en[2]) lowcnt++;
      @(negedge clk);
    end
    chk(lowcnt == SETTLE && clk_en[2], "R2", {lowcnt[30:0], clk_en[2]}, {SETTLE[30:0], 1'b1});

    // R4: exact fall latency
    wr(4'h2, 32'h0);
    lowcnt = 0;
    for (int k = 0; k < SETTLE; k++) begin
      if (clk_en[2]) lowcnt++;
      @(negedge clk);
    end
    chk(lowcnt == SETTLE && !clk_en[2], "R4", {lowcnt[30:0], clk_en[2]}, {SETTLE[30:0], 1'b0});

    // R5: request withdrawn before settling
    wr(4'h3, 32'h1);
    @(negedge clk);
    wr(4'h3, 32'h0);
    lowcnt = 0;
    for (int k = 0; k < 2 * SETTLE; k++) begin
      if (clk_en[3]) lowcnt++;
      @(negedge clk);
    end
    chk(lowcnt == 0, "R5", lowcnt, 0);
    rd(4'h3, v);
    chk(v == 32'h8000_0000, "R5", v, 32'h8000_0000);

    // R7: PLL already active, re-vote must not drop it
    wr(4'h9, 32'h1);
    lowcnt = 0;
    for (int k = 0; k < 2 * LOCK; k++) begin
      if (!pll_active) lowcnt++;
      @(negedge clk);
    end
    chk(lowcnt == 0, "R7", lowcnt, 0);

    // R9: clk_en agrees with the reported status in steady state
    wr(4'h8, 32'h1 << (VLSB + 1));
    repeat (SETTLE + 2) @(negedge clk);
    for (int b = 0; b < NB; b++) begin
      rd(4'(b), v);
      chk(clk_en[b] == (v[31:28] == 4'h0 || v[31:28] == 4'h2), "R9", {v[31:28], 3'd0, clk_en[b]}, {v[31:28], 4'd0});
    end
    chk(clk_en == 4'b0011, "R9", clk_en, 4'b0011);

    // R10: rdata holds without rd_en while state changes
    rd(4'h0, held);
    wr(4'h0, 32'h0);
    repeat (SETTLE + 2) @(negedge clk);
    chk(rdata === held, "R10", rdata, held);
    rd(4'h0, v);
    chk(v == 32'h8000_0000, "R10", v, 32'h8000_0000);

    finish_run();
  end
endmodule